// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block sits beside a processor's control unit and decides, on every clock, whether the interrupt level offered by an external prioritizer may be taken. It checks the offered level against the current status word and against the raw request and enable vectors. When the level qualifies, it performs the state changes that go with entering the interrupt in a single step: it saves the program counter and status, updates the status word, records a cause code and produces the new program counter.

Levels above 1 are high-priority interrupts. Each one saves its context into its own pair of saved-PC and saved-status registers and jumps straight to its own vector. Level 1 is not vectored directly. It becomes a general exception whose class depends on the status mode bits: a user exception, a kernel exception, or a double exception when the exception-mode bit is already set.

All vector addresses are parameters. They can be moved as a group by a runtime vector-base value. The saved registers are read back through a small select/data read port.

Top module: `irq_entry_ctrl`

## Requirements
- R1: An offered level L is accepted only if L is strictly greater than the current status level, L is no greater than NLEVEL (default 6), and LEVEL_MASK[L] & int_set & int_enable is non-zero. Default masks: level 1 lines 3:0, level 2 lines 5:4, level 3 lines 7:6, level 4 lines 9:8, level 5 lines 11:10, level 6 lines 13:12, level 7 lines 15:14.
- R2: When no level is accepted, nothing changes: saved registers, the cause register, entry_kind, next_pc and the next status fields all keep their values.
- R3: On accepting L > 1, cur_pc is stored in saved-PC register L and the current status word is stored in saved-status register L.
- R4: On accepting L > 1, the next status has level = L, excm = 1 and um unchanged. entry_kind is 1 (high-priority) and next_pc is the vector for level L (default 0x4000_0100 + 0x40*L).
- R5: On accepting level 1, the cause register is loaded with code 4.
- R6: On accepting level 1 with ps_excm = 1, entry_kind is 4 (double) and next_pc is the double vector (default 0x4000_03C0). cur_pc goes to the dedicated double-exception PC register when HAS_DEPC = 1, otherwise to saved-PC register 1.
- R7: On accepting level 1 with ps_excm = 0, cur_pc goes to saved-PC register 1. The exception is user (kind 2, vector 0x4000_0340) when ps_um = 1, and kernel (kind 3, vector 0x4000_0300) otherwise.
- R8: Every level-1 entry sets excm and leaves the status level and um unchanged.
- R9: With RELOC = 1, next_pc = default vector − DEF_VECBASE (default 0x4000_0000) + vecbase. With RELOC = 0, next_pc is the default vector.
- R10: entry_taken is high for exactly the one cycle after the edge that accepted a level. next_pc, entry_kind and the next status fields update at that same edge.
- R11: rd_data selects by rd_sel: 0 = cause, 1..7 = saved PC of that level, 8 = double-exception PC, 9..15 = saved status of level rd_sel−8. A status word has level in bits 2:0, excm in bit 4 and um in bit 5. Registers that are not built read 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_level | input | 3 | Interrupt level offered this cycle (0 = none) |
| int_set | input | NLINES | Raw interrupt request lines |
| int_enable | input | NLINES | Per-line enables |
| ps_level | input | 3 | Current status interrupt level |
| ps_excm | input | 1 | Current exception-mode bit |
| ps_um | input | 1 | Current user-mode bit |
| cur_pc | input | XLEN | Program counter to be saved |
| vecbase | input | XLEN | Runtime vector base |
| rd_sel | input | 4 | Saved-register read select |
| entry_taken | output | 1 | One-cycle entry pulse |
| entry_kind | output | 3 | 0 none, 1 high-priority, 2 user, 3 kernel, 4 double |
| next_pc | output | XLEN | Entry target address |
| next_level | output | 3 | Updated status level |
| next_excm | output | 1 | Updated exception-mode bit |
| next_um | output | 1 | Updated user-mode bit |
| rd_data | output | XLEN | Read data for rd_sel |

## Verification
The assertions compare each registered entry result with the level and status that were presented on the previous cycle. They therefore assume that pend_level and the status inputs are settled before the edge and have no unknown bits. The scoreboard drives each offered level for one cycle and then returns to level 0, so a qualifying level is never held long enough to be taken twice. The status inputs used in each case are given explicitly, matching a caller that feeds back the updated status word.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int LVL_W      = 3;
    localparam int MAX_LEVELS = 7;
    localparam logic [7:0] LVL1_CAUSE = 8'd4;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic um;
        logic excm;
        lvl_t lvl;
    } stat_t;

    typedef enum logic [2:0] {
        ENT_NONE   = 3'd0,
        ENT_HIGH   = 3'd1,
        ENT_USER   = 3'd2,
        ENT_KERNEL = 3'd3,
        ENT_DOUBLE = 3'd4
    } entry_t;

    // status word layout: level 2:0, excm bit 4, um bit 5
    function automatic logic [5:0] stat_word(stat_t s);
        return {s.um, s.excm, 1'b0, s.lvl};
    endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_entry_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NLEVEL = 6,
    parameter logic [7:0][NLINES-1:0] LEVEL_MASK = '0
) (
    input  lvl_t              pend,
    input  lvl_t              cur_lvl,
    input  logic [NLINES-1:0] int_set,
    input  logic [NLINES-1:0] int_en,
    output logic              accept
);
    logic [NLINES-1:0] live;
    logic              above, in_range;

    always_comb begin
        live     = LEVEL_MASK[pend] & int_set & int_en;
        above    = pend > cur_lvl;
        in_range = int'(pend) <= NLEVEL;
        accept   = above && in_range && (|live);
    end
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
    import irq_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter bit RELOC = 1'b1,
    parameter logic [XLEN-1:0] DEF_VECBASE = '0,
    parameter logic [7:0][XLEN-1:0] INT_VEC = '0,
    parameter logic [XLEN-1:0] USER_VEC = '0,
    parameter logic [XLEN-1:0] KERNEL_VEC = '0,
    parameter logic [XLEN-1:0] DOUBLE_VEC = '0
) (
    input  entry_t            kind,
    input  lvl_t              lvl,
    input  logic [XLEN-1:0]   vecbase,
    output logic [XLEN-1:0]   target
);
    logic [XLEN-1:0] dflt;

    always_comb begin
        unique case (kind)
            ENT_HIGH:   dflt = INT_VEC[lvl];
            ENT_USER:   dflt = USER_VEC;
            ENT_KERNEL: dflt = KERNEL_VEC;
            ENT_DOUBLE: dflt = DOUBLE_VEC;
            default:    dflt = '0;
        endcase
    end

    generate
        if (RELOC) begin : g_reloc
            assign target = dflt - DEF_VECBASE + vecbase;
        end else begin : g_fixed
            logic [XLEN-1:0] vb_unused;
            assign vb_unused = vecbase;
            assign target    = dflt;
        end
    endgenerate
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
    import irq_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NLEVEL = 6,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we_pc,
    input  logic            we_stat,
    input  logic            we_dpc,
    input  logic            we_cause,
    input  lvl_t            wr_lvl,
    input  logic [XLEN-1:0] pc_in,
    input  stat_t           stat_in,
    input  logic [3:0]      rd_sel,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] epc_v [0:7];
    stat_t           eps_v [0:7];
    logic [XLEN-1:0] dpc_v;
    logic [XLEN-1:0] cause_q;

    generate
        for (genvar L = 0; L <= MAX_LEVELS; L++) begin : g_lvl
            if (L >= 1 && L <= NLEVEL) begin : g_pc
                logic [XLEN-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst)                                q <= '0;
                    else if (we_pc && int'(wr_lvl) == L)   q <= pc_in;
                end
                assign epc_v[L] = q;
            end else begin : g_no_pc
                assign epc_v[L] = '0;
            end
            if (L >= 2 && L <= NLEVEL) begin : g_st
                stat_t q;
                always_ff @(posedge clk) begin
                    if (rst)                                 q <= '0;
                    else if (we_stat && int'(wr_lvl) == L)  q <= stat_in;
                end
                assign eps_v[L] = q;
            end else begin : g_no_st
                assign eps_v[L] = '0;
            end
        end

        if (HAS_DEPC) begin : g_dpc
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)         q <= '0;
                else if (we_dpc) q <= pc_in;
            end
            assign dpc_v = q;
        end else begin : g_no_dpc
            logic dpc_unused;
            assign dpc_unused = we_dpc;
            assign dpc_v      = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)           cause_q <= '0;
        else if (we_cause) cause_q <= XLEN'(LVL1_CAUSE);
    end

    always_comb begin
        if (rd_sel[2:0] == 3'd0)
            rd_data = rd_sel[3] ? dpc_v : cause_q;
        else if (rd_sel[3])
            rd_data = XLEN'(stat_word(eps_v[rd_sel[2:0]]));
        else
            rd_data = epc_v[rd_sel[2:0]];
    end

    // R2: the cause register only moves when a write is requested
    p_cause_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we_cause |=> $stable(cause_q));

    // R6: the double-exception PC is never written together with a saved-PC slot
    p_dpc_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(we_dpc && we_pc));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NLINES = 16,
    parameter int NLEVEL = 6,
    parameter bit HAS_DEPC = 1'b1,
    parameter bit RELOC    = 1'b1,
    parameter logic [XLEN-1:0] DEF_VECBASE = 32'h4000_0000,
    parameter logic [7:0][XLEN-1:0] INT_VEC = {
        32'h4000_02C0, 32'h4000_0280, 32'h4000_0240, 32'h4000_0200,
        32'h4000_01C0, 32'h4000_0180, 32'h0000_0000, 32'h0000_0000},
    parameter logic [XLEN-1:0] USER_VEC   = 32'h4000_0340,
    parameter logic [XLEN-1:0] KERNEL_VEC = 32'h4000_0300,
    parameter logic [XLEN-1:0] DOUBLE_VEC = 32'h4000_03C0,
    parameter logic [7:0][NLINES-1:0] LEVEL_MASK = {
        16'hC000, 16'h3000, 16'h0C00, 16'h0300,
        16'h00C0, 16'h0030, 16'h000F, 16'h0000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        pend_level,
    input  logic [NLINES-1:0] int_set,
    input  logic [NLINES-1:0] int_enable,
    input  logic [2:0]        ps_level,
    input  logic              ps_excm,
    input  logic              ps_um,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   vecbase,
    input  logic [3:0]        rd_sel,
    output logic              entry_taken,
    output logic [2:0]        entry_kind,
    output logic [XLEN-1:0]   next_pc,
    output logic [2:0]        next_level,
    output logic              next_excm,
    output logic              next_um,
    output logic [XLEN-1:0]   rd_data
);
    stat_t           cur_stat, new_stat, stat_q;
    entry_t          kind, kind_q;
    logic            accept, taken_q;
    logic [XLEN-1:0] target, pc_q;
    logic            we_pc, we_stat, we_dpc, we_cause;
    lvl_t            wr_lvl;

    assign cur_stat = '{um: ps_um, excm: ps_excm, lvl: ps_level};

    irq_qualify #(
        .NLINES(NLINES), .NLEVEL(NLEVEL), .LEVEL_MASK(LEVEL_MASK)
    ) u_qualify (
        .pend(pend_level), .cur_lvl(ps_level),
        .int_set(int_set), .int_en(int_enable), .accept(accept)
    );

    always_comb begin
        if (!accept)                  kind = ENT_NONE;
        else if (pend_level > 3'd1)   kind = ENT_HIGH;
        else if (ps_excm)             kind = ENT_DOUBLE;
        else if (ps_um)               kind = ENT_USER;
        else                          kind = ENT_KERNEL;

        new_stat      = cur_stat;
        new_stat.excm = 1'b1;
        if (kind == ENT_HIGH) new_stat.lvl = pend_level;

        we_stat  = (kind == ENT_HIGH);
        we_dpc   = (kind == ENT_DOUBLE) && HAS_DEPC;
        we_pc    = accept && !we_dpc;
        we_cause = accept && (kind != ENT_HIGH);
        wr_lvl   = (kind == ENT_HIGH) ? pend_level : lvl_t'(1);
    end

    irq_vector_sel #(
        .XLEN(XLEN), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE),
        .INT_VEC(INT_VEC), .USER_VEC(USER_VEC),
        .KERNEL_VEC(KERNEL_VEC), .DOUBLE_VEC(DOUBLE_VEC)
    ) u_vector (
        .kind(kind), .lvl(pend_level), .vecbase(vecbase), .target(target)
    );

    irq_save_bank #(
        .XLEN(XLEN), .NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC)
    ) u_bank (
        .clk(clk), .rst(rst),
        .we_pc(we_pc), .we_stat(we_stat), .we_dpc(we_dpc), .we_cause(we_cause),
        .wr_lvl(wr_lvl), .pc_in(cur_pc), .stat_in(cur_stat),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            kind_q  <= ENT_NONE;
            pc_q    <= '0;
            stat_q  <= '0;
        end else begin
            taken_q <= accept;
            if (accept) begin
                kind_q <= kind;
                pc_q   <= target;
                stat_q <= new_stat;
            end
        end
    end

    assign entry_taken = taken_q;
    assign entry_kind  = kind_q;
    assign next_pc     = pc_q;
    assign next_level  = stat_q.lvl;
    assign next_excm   = stat_q.excm;
    assign next_um     = stat_q.um;

    // R1: an entry implies the offered level was above the old level and in range
    p_accept_rule_r1: assert property (@(posedge clk) disable iff (rst)
        taken_q |-> ($past(pend_level) > $past(ps_level)) &&
                    (int'($past(pend_level)) <= NLEVEL));

    // R2: without an entry the presented results hold
    p_hold_outputs_r2: assert property (@(posedge clk) disable iff (rst)
        !taken_q |-> $stable(pc_q) && $stable(stat_q));

    // R8: any entry leaves the exception-mode bit set
    p_excm_set_r8: assert property (@(posedge clk) disable iff (rst)
        taken_q |-> stat_q.excm);

    // R4: a high-priority entry raises the status level to the offered level
    p_high_level_r4: assert property (@(posedge clk) disable iff (rst)
        (taken_q && kind_q == ENT_HIGH) |-> stat_q.lvl == $past(pend_level));
endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

    localparam logic [2:0] K_NONE = 3'd0, K_HIGH = 3'd1, K_USER = 3'd2,
                           K_KERNEL = 3'd3, K_DOUBLE = 3'd4;
    localparam logic [31:0] DBASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  pend_level = '0;
    logic [15:0] int_set = '0, int_enable = '0;
    logic [2:0]  ps_level = '0;
    logic        ps_excm = 1'b0, ps_um = 1'b0;
    logic [31:0] cur_pc = '0, vecbase = DBASE;
    logic [3:0]  rd_sel = '0;
    logic        entry_taken;
    logic [2:0]  entry_kind;
    logic [31:0] next_pc, rd_data;
    logic [2:0]  next_level;
    logic        next_excm, next_um;

    irq_entry_ctrl i_irq_entry_ctrl (
        .clk(clk), .rst(rst), .pend_level(pend_level), .int_set(int_set),
        .int_enable(int_enable), .ps_level(ps_level), .ps_excm(ps_excm),
        .ps_um(ps_um), .cur_pc(cur_pc), .vecbase(vecbase), .rd_sel(rd_sel),
        .entry_taken(entry_taken), .entry_kind(entry_kind), .next_pc(next_pc),
        .next_level(next_level), .next_excm(next_excm), .next_um(next_um),
        .rd_data(rd_data)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic        taken;
        logic [2:0]  kind;
        logic [31:0] pc;
        logic [5:0]  st;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    // bench model, built from the requirements
    logic [31:0] m_epc [0:7];
    logic [5:0]  m_eps [0:7];
    logic [31:0] m_dpc = '0, m_cause = '0, m_pc = '0;
    logic [5:0]  m_stat = '0;
    logic [2:0]  m_kind = K_NONE;

    function automatic logic [5:0] sw(logic um, logic ex, logic [2:0] lv);
        return {um, ex, 1'b0, lv};
    endfunction

    function automatic logic [15:0] mask_of(logic [2:0] l);
        return (l == 0) ? 16'h0000 : (16'h0003 << (2 * l)) | ((l == 1) ? 16'h0003 : 16'h0000);
    endfunction

    task automatic apply(input logic [2:0] pl, input logic [15:0] st, input logic [15:0] en,
                         input logic [2:0] lv, input logic ex, input logic um,
                         input logic [31:0] pc, input logic [31:0] vb, input string tag);
        logic        acc;
        logic [31:0] base;
        @(negedge clk);
        pend_level = pl; int_set = st; int_enable = en;
        ps_level = lv; ps_excm = ex; ps_um = um; cur_pc = pc; vecbase = vb;
        acc = (pl > lv) && (pl <= 3'd6) && ((mask_of(pl) & st & en) != 16'h0);
        if (acc) begin
            if (pl > 3'd1) begin
                m_kind = K_HIGH;
                base = 32'h4000_0100 + 32'h40 * {29'd0, pl};
                m_epc[pl] = pc;
                m_eps[pl] = sw(um, ex, lv);
                m_stat = sw(um, 1'b1, pl);
            end else begin
                m_cause = 32'd4;
                if (ex) begin
                    m_kind = K_DOUBLE; base = 32'h4000_03C0; m_dpc = pc;
                end else begin
                    m_epc[1] = pc;
                    m_kind = um ? K_USER : K_KERNEL;
                    base = um ? 32'h4000_0340 : 32'h4000_0300;
                end
                m_stat = sw(um, 1'b1, lv);
            end
            m_pc = base - DBASE + vb;
        end
        sb.push_back('{acc, m_kind, m_pc, m_stat, tag});
        @(negedge clk);
        pend_level = 3'd0;
        sb.push_back('{1'b0, m_kind, m_pc, m_stat, "R10 pulse ends"});
    endtask

    task automatic chk_rd(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_sel = sel;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_sel=%0d actual=%h expected=%h", tag, sel, rd_data, exp);
        end
    endtask

    // monitor: one scoreboard entry per clock, sampled after the edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (entry_taken !== e.taken || entry_kind !== e.kind || next_pc !== e.pc ||
                {next_um, next_excm, 1'b0, next_level} !== e.st) begin
                n_bad++;
                $display("FAIL %s: actual taken=%b kind=%0d pc=%h st=%h expected taken=%b kind=%0d pc=%h st=%h",
                         e.tag, entry_taken, entry_kind, next_pc,
                         {next_um, next_excm, 1'b0, next_level},
                         e.taken, e.kind, e.pc, e.st);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_epc[i] = '0; m_eps[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        @(negedge clk);
        n_chk++;
        if (entry_taken !== 1'b0 || next_pc !== 32'h0) begin
            n_bad++;
            $display("FAIL R11 reset: actual taken=%b pc=%h expected 0 0", entry_taken, next_pc);
        end
        chk_rd(4'd0, 32'h0, "R11 reset cause");
        chk_rd(4'd1, 32'h0, "R11 reset level-1 PC");

        // R4 R3: level 3 from level 1 in user mode
        apply(3'd3, 16'h0040, 16'h0040, 3'd1, 1'b0, 1'b1, 32'h0000_1000, DBASE, "R4 level3 entry");
        chk_rd(4'd3, 32'h0000_1000, "R3 saved PC level3");
        chk_rd(4'd11, 32'h0000_0021, "R3 saved status level3");

        // R1: equal level, level beyond NLEVEL, masked-off line
        apply(3'd2, 16'h0010, 16'h0010, 3'd2, 1'b0, 1'b0, 32'h0000_1100, DBASE, "R1 equal level");
        apply(3'd7, 16'hC000, 16'hC000, 3'd0, 1'b0, 1'b0, 32'h0000_1200, DBASE, "R1 above NLEVEL");
        apply(3'd5, 16'h0C00, 16'h0000, 3'd0, 1'b0, 1'b0, 32'h0000_1300, DBASE, "R1 not enabled");
        apply(3'd4, 16'h0030, 16'hFFFF, 3'd0, 1'b0, 1'b0, 32'h0000_1400, DBASE, "R1 wrong line");
        chk_rd(4'd0, 32'h0, "R2 cause untouched");
        chk_rd(4'd2, 32'h0, "R2 level2 PC untouched");
        chk_rd(4'd7, 32'h0, "R11 unbuilt level7 PC");

        // R7 R5 R8: level 1 user then kernel
        apply(3'd1, 16'h0001, 16'h0001, 3'd0, 1'b0, 1'b1, 32'h0000_2000, DBASE, "R7 user entry");
        chk_rd(4'd0, 32'd4, "R5 cause code");
        chk_rd(4'd1, 32'h0000_2000, "R7 level1 PC user");
        apply(3'd1, 16'h0008, 16'h0008, 3'd0, 1'b0, 1'b0, 32'h0000_2400, DBASE, "R7 kernel entry");
        chk_rd(4'd1, 32'h0000_2400, "R7 level1 PC kernel");

        // R6: double exception
        apply(3'd1, 16'h0002, 16'h0002, 3'd0, 1'b1, 1'b0, 32'h0000_3000, DBASE, "R6 double entry");
        chk_rd(4'd8, 32'h0000_3000, "R6 double PC");
        chk_rd(4'd1, 32'h0000_2400, "R6 level1 PC kept");

        // R9: relocated vectors
        apply(3'd6, 16'h1000, 16'h1000, 3'd2, 1'b0, 1'b0, 32'h0000_4000, 32'h2000_1000, "R9 level6 relocated");
        chk_rd(4'd14, 32'h0000_0002, "R3 saved status level6");
        chk_rd(4'd6, 32'h0000_4000, "R3 saved PC level6");
        apply(3'd1, 16'h0004, 16'h0004, 3'd0, 1'b0, 1'b1, 32'h0000_5000, 32'h2000_1000, "R9 user relocated");
        apply(3'd2, 16'h0020, 16'h0020, 3'd1, 1'b1, 1'b1, 32'h0000_6000, DBASE, "R4 level2 keeps um");
        chk_rd(4'd10, 32'h0000_0031, "R3 saved status level2");
        chk_rd(4'd15, 32'h0, "R11 unbuilt level7 status");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule